// File: doc/BRIEF.md
# Big-Endian Byte-Addressable Scratchpad Port

The block is the load/store front end of a 4 KB data scratchpad. It holds the storage as 1024 words of 32 bits in a synchronous single-port RAM. A requester can read or write a byte, a halfword or a word at any byte address, and it always sees big-endian data. Inside the RAM each word keeps its bytes in little-endian lanes. The port therefore moves byte and halfword accesses onto the right lanes by XOR-ing the low address bits.

A request is taken when `reqValid` and `reqReady` are both high on a clock edge. An access on its natural alignment is a single RAM operation, and it completes one cycle later. A halfword at an odd address, or a word whose low two address bits are not zero, is broken up. The port runs it as a series of single-byte operations over consecutive addresses, most significant byte first, and holds `reqReady` low while the series runs. The port builds the big-endian read result from the bytes it collects. Each byte address is cut to 12 bits, so a series that runs past the top of the window carries on at address 0. Every access ends with a one-cycle `doneValid` pulse, and a read result appears on `rdData` in the same cycle as that pulse.

Top module: `be_scratch_port`

## Requirements
- R1: Only the low 12 bits of `reqAddr` select a location, so addresses that differ only above bit 11 reach the same byte.
- R2: A byte access reaches the physical lane given by the low two address bits XOR 3. As a result, the byte at address 4k is bits 31:24 of word k as written by a word access, and the byte at 4k+3 is bits 7:0.
- R3: An aligned halfword access reaches the physical halfword slot given by address bit 1 XOR 1. As a result, the halfword at 4k is bits 31:16 of word k and the halfword at 4k+2 is bits 15:0.
- R4: An aligned word access reads or writes word address/4 without any swizzle. Every aligned access raises `doneValid` in the cycle after acceptance, and `reqReady` stays high throughout.
- R5: A halfword at an odd address runs as two byte accesses, and the byte at the lower address is bits 15:8 of the value. `doneValid` rises two cycles after acceptance, and `reqReady` is low for the one cycle between.
- R6: A word whose low two address bits are not zero runs as four byte accesses at the address and the next three addresses, most significant byte first. `doneValid` rises four cycles after acceptance, and `reqReady` is low for the three cycles between.
- R7: A split access that passes address 0xFFF continues at address 0x000.
- R8: A byte write or halfword write changes only the bytes it addresses, both in the single-operation case and in the split case.
- R9: Byte and halfword reads are zero-extended into `rdData`. `rdData` is zero in every cycle except the `doneValid` cycle of a read.
- R10: After reset, `reqReady` is high, `doneValid` is low and `rdData` is zero.

Size encoding on `reqSize`: 0 = byte, 1 = halfword, 2 = word (3 is treated as word).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Port can accept a request this cycle |
| reqAddr | input | REQ_AW (32) | Byte address; only bits 11:0 are used |
| reqSize | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 32 | Write value, right-justified big-endian |
| doneValid | output | 1 | One-cycle pulse when an access completes |
| rdData | output | 32 | Read result, valid with doneValid, zero otherwise |

## Verification
The hardest case to reach is a split access that crosses the top of the window. Only a misaligned word or halfword placed within three bytes of 0xFFF reaches it, and both ends of the window must already hold known data for the result to mean anything. The stimulus first writes aligned words at 0xFFC and 0x000. It then issues a misaligned word write at 0xFFE that spills into address 0. After that it reads back across the seam with aligned and misaligned accesses of both sizes. Split writes are also set next to data that is already known, so that any stray lane enable would show up as a corrupted neighbour byte.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  localparam int SPAD_AW  = 12;             // byte address bits of the window
  localparam int LANES    = 4;              // bytes per storage word
  localparam int DATA_W   = 8 * LANES;
  localparam int WORD_AW  = SPAD_AW - $clog2(LANES);
  localparam int DEPTH    = 1 << WORD_AW;

  typedef logic [SPAD_AW-1:0] spadAddr_t;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       accept;   // request captured this cycle
    logic       issue;    // RAM operation this cycle
    logic       split;    // operation is one byte of a split series
    logic [1:0] idx;      // byte index inside the series
  } ctlStrobe_t;
endpackage

// File: rtl/bsp_ram.sv
module bsp_ram
  import bsp_pkg::*;
(
  input  logic               clk,
  input  logic               en,
  input  logic               we,
  input  logic [LANES-1:0]   be,
  input  logic [WORD_AW-1:0] addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        for (int b = 0; b < LANES; b++) begin
          if (be[b]) mem[addr][8*b +: 8] <= wdata[8*b +: 8];
        end
      end
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/bsp_ctrl.sv
module bsp_ctrl
  import bsp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqSize,
  input  logic [1:0] reqAddrLo,
  output logic       reqReady,
  output logic       doneValid,
  output ctlStrobe_t strobe
);
  logic       busyQ;
  logic [1:0] idxQ;
  logic [1:0] lastIdxQ;
  logic       doneQ;
  logic       isHalf, isWord, splitNow, accept, finalIssue;

  always_comb begin
    isHalf   = (reqSize == SZ_HALF);
    isWord   = reqSize[1];
    splitNow = (isHalf & reqAddrLo[0]) | (isWord & (|reqAddrLo));
    accept   = reqValid & ~busyQ;
    strobe.accept = accept;
    strobe.issue  = accept | busyQ;
    strobe.split  = busyQ ? 1'b1 : splitNow;
    strobe.idx    = busyQ ? idxQ : 2'd0;
    finalIssue    = busyQ ? (idxQ == lastIdxQ) : (accept & ~splitNow);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      idxQ     <= 2'd0;
      lastIdxQ <= 2'd0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= finalIssue;
      if (busyQ) begin
        if (idxQ == lastIdxQ) busyQ <= 1'b0;
        else                  idxQ  <= idxQ + 2'd1;
      end else if (accept && splitNow) begin
        busyQ    <= 1'b1;
        idxQ     <= 2'd1;
        lastIdxQ <= isWord ? 2'd3 : 2'd1;
      end
    end
  end

  assign reqReady  = ~busyQ;
  assign doneValid = doneQ;

  // R5: a split access blocks the next request
  p_split_blocks_r5: assert property (@(posedge clk) disable iff (!rstN)
    accept && splitNow |=> !reqReady);

  // R4: aligned access finishes next cycle with the port still open
  p_aligned_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    accept && !splitNow |=> doneValid && reqReady);

  // R6: misaligned word holds the port for three cycles, done on the fourth
  p_word_split_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    accept && splitNow && isWord |=> !reqReady ##1 !reqReady ##1 !reqReady ##1 (doneValid && reqReady));
endmodule

// File: rtl/bsp_dpath.sv
module bsp_dpath
  import bsp_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  spadAddr_t          reqAddr,
  input  logic [1:0]         reqSize,
  input  logic               reqWrite,
  input  logic [DATA_W-1:0]  reqWdata,
  input  logic               doneValid,
  output logic [DATA_W-1:0]  rdData,
  output logic               ramEn,
  output logic               ramWe,
  output logic [LANES-1:0]   ramBe,
  output logic [WORD_AW-1:0] ramAddr,
  output logic [DATA_W-1:0]  ramWdata,
  input  logic [DATA_W-1:0]  ramRdata
);
  // request captured at acceptance
  spadAddr_t         savAddr;
  logic [1:0]        savSize;
  logic              savWrite;
  logic [DATA_W-1:0] savData;
  // description of the RAM operation issued in the previous cycle
  logic              lastIssue, lastSplit, lastWrite;
  logic [1:0]        lastSize, lastLo;
  logic [23:0]       asmQ;

  spadAddr_t         curAddr, byteAddr;
  logic [1:0]        curSize, laneSel, rdLane;
  logic              curWrite;
  logic [DATA_W-1:0] curData, value;
  logic [7:0]        pickByte, byteNow;
  logic [15:0]       halfNow;

  always_comb begin
    curAddr  = strobe.accept ? reqAddr  : savAddr;
    curSize  = strobe.accept ? reqSize  : savSize;
    curWrite = strobe.accept ? reqWrite : savWrite;
    curData  = strobe.accept ? reqWdata : savData;
    byteAddr = curAddr + spadAddr_t'(strobe.idx);
    laneSel  = byteAddr[1:0] ^ 2'b11;

    if (curSize[1]) pickByte = curData[{~strobe.idx, 3'b000} +: 8];
    else            pickByte = curData[{~strobe.idx[0], 3'b000} +: 8];

    if (strobe.split) begin
      ramBe    = 4'b0001 << laneSel;
      ramWdata = {LANES{pickByte}};
    end else begin
      unique case (curSize)
        SZ_BYTE: begin
          ramBe    = 4'b0001 << laneSel;
          ramWdata = {LANES{curData[7:0]}};
        end
        SZ_HALF: begin
          ramBe    = byteAddr[1] ? 4'b0011 : 4'b1100;
          ramWdata = {2{curData[15:0]}};
        end
        default: begin
          ramBe    = 4'b1111;
          ramWdata = curData;
        end
      endcase
    end

    ramEn   = strobe.issue;
    ramWe   = strobe.issue & curWrite;
    ramAddr = byteAddr[SPAD_AW-1:2];
  end

  // read side: lane of the previous operation
  always_comb begin
    rdLane  = lastLo ^ 2'b11;
    byteNow = ramRdata[{rdLane, 3'b000} +: 8];
    halfNow = ramRdata[{~lastLo[1], 4'b0000} +: 16];
    if (lastSplit) begin
      value = lastSize[1] ? {asmQ, byteNow} : {16'd0, asmQ[7:0], byteNow};
    end else begin
      unique case (lastSize)
        SZ_BYTE: value = {24'd0, byteNow};
        SZ_HALF: value = {16'd0, halfNow};
        default: value = ramRdata;
      endcase
    end
    rdData = (doneValid && !lastWrite) ? value : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      savAddr   <= '0;
      savSize   <= 2'd0;
      savWrite  <= 1'b0;
      savData   <= '0;
      lastIssue <= 1'b0;
      lastSplit <= 1'b0;
      lastWrite <= 1'b0;
      lastSize  <= 2'd0;
      lastLo    <= 2'd0;
      asmQ      <= '0;
    end else begin
      if (strobe.accept) begin
        savAddr  <= reqAddr;
        savSize  <= reqSize;
        savWrite <= reqWrite;
        savData  <= reqWdata;
      end
      lastIssue <= strobe.issue;
      if (strobe.issue) begin
        lastSplit <= strobe.split;
        lastSize  <= curSize;
        lastLo    <= byteAddr[1:0];
        lastWrite <= curWrite;
      end
      if (lastIssue && lastSplit && !lastWrite) asmQ <= {asmQ[15:0], byteNow};
    end
  end

  // R7: successive bytes of a series step by one and wrap at the window top
  p_seq_addr_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issue && strobe.split && strobe.idx != 2'd0 |->
      byteAddr == spadAddr_t'($past(byteAddr) + 1'b1));

  // R8: each byte of a split series enables exactly one lane
  p_split_be_r8: assert property (@(posedge clk) disable iff (!rstN)
    ramWe && strobe.split |-> $onehot(ramBe));

  // R3: aligned halfword writes cover one whole halfword slot
  p_half_be_r3: assert property (@(posedge clk) disable iff (!rstN)
    ramWe && !strobe.split && curSize == SZ_HALF |-> (ramBe == 4'b0011 || ramBe == 4'b1100));
endmodule

// File: rtl/be_scratch_port.sv
module be_scratch_port
  import bsp_pkg::*;
#(
  parameter int REQ_AW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [REQ_AW-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              doneValid,
  output logic [DATA_W-1:0] rdData
);
  ctlStrobe_t         strobe;
  logic               ramEn, ramWe;
  logic [LANES-1:0]   ramBe;
  logic [WORD_AW-1:0] ramAddr;
  logic [DATA_W-1:0]  ramWdata, ramRdata;
  logic               unusedAddrHi;

  // bits above the window take no part in the access
  assign unusedAddrHi = ^reqAddr[REQ_AW-1:SPAD_AW];

  bsp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqSize   (reqSize),
    .reqAddrLo (reqAddr[1:0]),
    .reqReady  (reqReady),
    .doneValid (doneValid),
    .strobe    (strobe)
  );

  bsp_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqAddr   (reqAddr[SPAD_AW-1:0]),
    .reqSize   (reqSize),
    .reqWrite  (reqWrite),
    .reqWdata  (reqWdata),
    .doneValid (doneValid),
    .rdData    (rdData),
    .ramEn     (ramEn),
    .ramWe     (ramWe),
    .ramBe     (ramBe),
    .ramAddr   (ramAddr),
    .ramWdata  (ramWdata),
    .ramRdata  (ramRdata)
  );

  bsp_ram u_ram (
    .clk   (clk),
    .en    (ramEn),
    .we    (ramWe),
    .be    (ramBe),
    .addr  (ramAddr),
    .wdata (ramWdata),
    .rdata (ramRdata)
  );
endmodule

// File: tb/be_scratch_port_tb.sv
module be_scratch_port_tb;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqSize = 2'd0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqWdata = '0;
  logic        reqReady, doneValid;
  logic [31:0] rdData;

  int checks = 0;
  int fails  = 0;
  int strayData = 0;

  always #2.5 clk = ~clk;

  be_scratch_port u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .doneValid(doneValid), .rdData(rdData)
  );

  // {req, size, write, addr, wdata, expected read, latency}
  localparam int NV = 34;
  localparam logic [105:0] VEC [NV] = '{
    {4'd4,  2'd2, 1'b1, 32'h0000_0000, 32'h1122_3344, 32'h0, 3'd1}, // R4
    {4'd4,  2'd2, 1'b0, 32'h0000_0000, 32'h0, 32'h1122_3344, 3'd1}, // R4
    {4'd2,  2'd0, 1'b0, 32'h0000_0000, 32'h0, 32'h0000_0011, 3'd1}, // R2
    {4'd2,  2'd0, 1'b0, 32'h0000_0001, 32'h0, 32'h0000_0022, 3'd1}, // R2
    {4'd2,  2'd0, 1'b0, 32'h0000_0003, 32'h0, 32'h0000_0044, 3'd1}, // R2
    {4'd3,  2'd1, 1'b0, 32'h0000_0000, 32'h0, 32'h0000_1122, 3'd1}, // R3
    {4'd3,  2'd1, 1'b0, 32'h0000_0002, 32'h0, 32'h0000_3344, 3'd1}, // R3
    {4'd5,  2'd1, 1'b0, 32'h0000_0001, 32'h0, 32'h0000_2233, 3'd2}, // R5
    {4'd4,  2'd2, 1'b1, 32'h0000_0004, 32'h5566_7788, 32'h0, 3'd1}, // R4
    {4'd6,  2'd2, 1'b0, 32'h0000_0002, 32'h0, 32'h3344_5566, 3'd4}, // R6
    {4'd6,  2'd2, 1'b0, 32'h0000_0003, 32'h0, 32'h4455_6677, 3'd4}, // R6
    {4'd6,  2'd2, 1'b0, 32'h0000_0001, 32'h0, 32'h2233_4455, 3'd4}, // R6
    {4'd8,  2'd0, 1'b1, 32'h0000_0005, 32'h0000_00A5, 32'h0, 3'd1}, // R8
    {4'd8,  2'd2, 1'b0, 32'h0000_0004, 32'h0, 32'h55A5_7788, 3'd1}, // R8
    {4'd8,  2'd1, 1'b1, 32'h0000_0006, 32'h0000_BEEF, 32'h0, 3'd1}, // R8
    {4'd8,  2'd2, 1'b0, 32'h0000_0004, 32'h0, 32'h55A5_BEEF, 3'd1}, // R8
    {4'd5,  2'd1, 1'b1, 32'h0000_0001, 32'h0000_C0DE, 32'h0, 3'd2}, // R5
    {4'd8,  2'd2, 1'b0, 32'h0000_0000, 32'h0, 32'h11C0_DE44, 3'd1}, // R8
    {4'd4,  2'd2, 1'b1, 32'h0000_0008, 32'h0, 32'h0, 3'd1},         // R4
    {4'd4,  2'd2, 1'b1, 32'h0000_000C, 32'h0, 32'h0, 3'd1},         // R4
    {4'd6,  2'd2, 1'b1, 32'h0000_000A, 32'hDEAD_BEEF, 32'h0, 3'd4}, // R6
    {4'd6,  2'd2, 1'b0, 32'h0000_0008, 32'h0, 32'h0000_DEAD, 3'd1}, // R6
    {4'd6,  2'd2, 1'b0, 32'h0000_000C, 32'h0, 32'hBEEF_0000, 3'd1}, // R6
    {4'd6,  2'd2, 1'b0, 32'h0000_000A, 32'h0, 32'hDEAD_BEEF, 3'd4}, // R6
    {4'd4,  2'd2, 1'b1, 32'h0000_0FFC, 32'hCAFE_F00D, 32'h0, 3'd1}, // R4
    {4'd7,  2'd2, 1'b1, 32'h0000_0FFE, 32'h0102_0304, 32'h0, 3'd4}, // R7
    {4'd7,  2'd2, 1'b0, 32'h0000_0FFC, 32'h0, 32'hCAFE_0102, 3'd1}, // R7
    {4'd7,  2'd2, 1'b0, 32'h0000_0000, 32'h0, 32'h0304_DE44, 3'd1}, // R7
    {4'd7,  2'd2, 1'b0, 32'h0000_0FFF, 32'h0, 32'h0203_04DE, 3'd4}, // R7
    {4'd7,  2'd1, 1'b0, 32'h0000_0FFF, 32'h0, 32'h0000_0203, 3'd2}, // R7
    {4'd1,  2'd2, 1'b0, 32'h7000_0FFC, 32'h0, 32'hCAFE_0102, 3'd1}, // R1
    {4'd1,  2'd0, 1'b1, 32'hABCD_E002, 32'h0000_0077, 32'h0, 3'd1}, // R1
    {4'd1,  2'd2, 1'b0, 32'h0000_0000, 32'h0, 32'h0304_7744, 3'd1}, // R1
    {4'd9,  2'd0, 1'b0, 32'h0000_0002, 32'h0, 32'h0000_0077, 3'd1}  // R9
  };

  task automatic check(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] size, input logic wr, input logic [31:0] addr,
                        input logic [31:0] wdata, output logic [31:0] rd,
                        output int lat, output int rlow);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqSize = size; reqWrite = wr; reqAddr = addr; reqWdata = wdata;
    lat = 0; rlow = 0; rd = '0;
    @(posedge clk);
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      reqValid = 1'b0;
      lat++;
      if (!reqReady) rlow++;
      if (doneValid) begin
        rd = rdData;
        break;
      end
      if (rdData != 32'd0) strayData++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int lat, rlow, latReq;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check(reqReady == 1'b1, 10, "ready in reset", {31'd0, reqReady}, 32'd1);
    check(doneValid == 1'b0, 10, "done in reset", {31'd0, doneValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1 && doneValid == 1'b0 && rdData == 32'd0, 10, "idle after reset",
          {reqReady, doneValid, rdData[29:0]}, 32'h8000_0000);

    for (int i = 0; i < NV; i++) begin
      logic [105:0] v;
      int req;
      v = VEC[i];
      req = int'(v[105:102]);
      access(v[101:100], v[99], v[98:67], v[66:35], rd, lat, rlow);
      if (v[99]) check(rd == 32'd0, 9, $sformatf("write %0d rdData", i), rd, 32'd0);
      else       check(rd == v[34:3], req, $sformatf("read %0d data", i), rd, v[34:3]);
      latReq = (v[2:0] == 3'd1) ? 4 : ((v[2:0] == 3'd2) ? 5 : 6);
      check(lat == int'(v[2:0]), latReq, $sformatf("vector %0d latency", i), lat, {29'd0, v[2:0]});
      check(rlow == int'(v[2:0]) - 1, latReq, $sformatf("vector %0d ready low", i), rlow,
            {29'd0, v[2:0]} - 32'd1);
    end

    // R9: rdData stayed zero outside done cycles
    check(strayData == 0, 9, "rdData outside done", strayData, 32'd0);

    // R8: byte write at split position preserves neighbours
    access(2'd0, 1'b1, 32'h0000_0FFD, 32'h0000_0099, rd, lat, rlow);
    access(2'd2, 1'b0, 32'h0000_0FFC, 32'h0, rd, lat, rlow);
    check(rd == 32'hCA99_0102, 8, "byte write neighbours", rd, 32'hCA99_0102);

    // R5: odd halfword write that wraps (R7)
    access(2'd1, 1'b1, 32'h0000_0FFF, 32'h0000_ABCD, rd, lat, rlow);
    access(2'd2, 1'b0, 32'h0000_0000, 32'h0, rd, lat, rlow);
    check(rd == 32'hCD04_7744, 7, "wrapped half low byte", rd, 32'hCD04_7744);
    access(2'd2, 1'b0, 32'h0000_0FFC, 32'h0, rd, lat, rlow);
    check(rd == 32'hCA99_01AB, 5, "wrapped half high byte", rd, 32'hCA99_01AB);

    // R9: byte read zero-extended with top bit set
    access(2'd0, 1'b0, 32'h0000_0FFC, 32'h0, rd, lat, rlow);
    check(rd == 32'h0000_00CA, 9, "byte zero-extend", rd, 32'h0000_00CA);

    // R10: reset mid-series returns to idle
    @(negedge clk);
    reqValid = 1'b1; reqSize = 2'd2; reqWrite = 1'b0; reqAddr = 32'h1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1 && doneValid == 1'b0, 10, "reset during series",
          {30'd0, reqReady, doneValid}, 32'd2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule